// File: doc/BRIEF.md
# Debug halt controller

This block holds the halting-debug control word of a processor core and runs a small halt/run state machine around it. A debugger, or software running on the core, writes a keyed control word that enables debug, requests a halt, arms single stepping, masks interrupts and allows a snap stall. A second word holds vector-catch enables. With catches armed, matching fault pulses from the core turn into halt requests, and so does a warm reset.

The block drives halt, step, interrupt-mask and snap-stall controls toward the core. Each of these is gated by the debug enable. Halt and step are also gated by the core's security state against a secure-debug-enable input. When the core acknowledges a halt, the block reports that the core is halted. There are two synchronous reset domains. The cold reset clears everything. The warm reset clears the run controls but keeps the debug enable and the catch enables.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A control write (`wr_sel`=0) changes stored bits only when `wr_data[31:16]` equals 16'hA05F. Any other key value leaves the control word unchanged.
- R2: Control word layout, as returned by a read with `rd_sel`=0 one cycle later: bit 0 debug enable, bit 1 halt request, bit 2 step, bit 3 interrupt mask, bit 5 snap stall, bit 17 halted status. All other bits read 0.
- R3: Bit 0 changes only on a keyed write with `wr_from_dbg`=1. Software writes leave it unchanged. A cold reset clears it and a warm reset keeps it.
- R4: While the debug enable is 0, `halt_o`, `step_o`, `mask_o` and `snap_o` are 0 whatever the stored bits hold.
- R5: `halt_o` and `step_o` are 0 while `core_secure`=1 and `sec_dbg_en`=0. A write to bit 5 is ignored while `sec_dbg_en`=0.
- R6: With debug enabled, a `dbg_event` pulse sets the halt bit. Writing 0 to it drops `halt_o`, and a warm reset clears it.
- R7: Catch word (`wr_sel`=1, written by either master without a key; read with `rd_sel`=1 in bits 7:0): bit 0 reset catch, bits 1..7 arm `fault_vec[0..6]`, where `fault_vec[6]` is the secure fault. A pulse on an armed line sets the halt bit only when debug is enabled. Lines 0..5 are ignored while `core_secure`=1 and `sec_dbg_en`=0, and line 6 is ignored while `sec_dbg_en`=0. A cold reset clears the catch word.
- R8: A warm reset with the reset catch and debug enable both set leaves the halt bit at 1, whatever the security state.
- R9: `halted_o` (read in bit 17) rises on the cycle after `core_halt_ack` while `halt_o` is 1. It falls together with `halt_o`.
- R10: While `step_o`=1 and the halt bit is 0, a `step_done` pulse sets the halt bit again.
- R11: The controls update one cycle after the stored state or the security inputs change. Both resets clear the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| cold_rst | input | 1 | Cold reset, synchronous, active high |
| wr_en | input | 1 | Write strobe |
| wr_from_dbg | input | 1 | 1: the write comes from the debugger, 0: from software |
| wr_sel | input | 1 | 0: control word, 1: catch word |
| wr_data | input | 32 | Write data (key in 31:16 for the control word) |
| rd_sel | input | 1 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Registered read data |
| sec_dbg_en | input | 1 | Secure debug permitted |
| core_secure | input | 1 | Core is in secure state |
| dbg_event | input | 1 | Debug event pulse (breakpoint) |
| fault_vec | input | 7 | Fault pulses for the vector catches |
| step_done | input | 1 | Core completed the stepped instruction |
| core_halt_ack | input | 1 | Core reports it has stopped |
| halt_o | output | 1 | Halt request to the core |
| step_o | output | 1 | Single-step control |
| mask_o | output | 1 | Interrupt mask control |
| snap_o | output | 1 | Snap stall control |
| halted_o | output | 1 | Halted status |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-bit key in the upper half, and seven fault lines with the secure fault on the top line. With these values every catch line maps to a distinct bit that can be read back. The bench can therefore tell the ordinary fault lines, which are gated by security state, from the secure-fault line, which needs secure debug. It also separates the reset catch, which works through the warm-reset path. The key width puts halted status in the key field, so no write can reach it.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int EN_POS     = 0;
  localparam int HALT_POS   = 1;
  localparam int STEP_POS   = 2;
  localparam int MASK_POS   = 3;
  localparam int SNAP_POS   = 5;
  localparam int HALTED_POS = 17;

  typedef struct packed {
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbg_wr_decode.sv
module dbg_wr_decode #(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_from_dbg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sec_dbg_en,
  output logic              ctrl_we,
  output logic              en_we,
  output logic              snap_we,
  output logic              catch_we
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic key_ok;
  assign key_ok   = (wr_data[DATA_W-1:KEY_LSB] == KEY);
  assign ctrl_we  = wr_en & ~wr_sel & key_ok;
  assign en_we    = ctrl_we & wr_from_dbg;
  assign snap_we  = ctrl_we & sec_dbg_en;
  assign catch_we = wr_en & wr_sel;
endmodule

// File: rtl/dbg_catch_unit.sv
module dbg_catch_unit #(
  parameter int NUM_FAULT = 7,
  parameter int SEC_IDX   = NUM_FAULT - 1
) (
  input  logic                 clk,
  input  logic                 cold_rst,
  input  logic                 catch_we,
  input  logic [NUM_FAULT:0]   wr_bits,
  input  logic                 dbg_en,
  input  logic                 sec_dbg_en,
  input  logic                 core_secure,
  input  logic [NUM_FAULT-1:0] fault_vec,
  output logic [NUM_FAULT:0]   catch_q,
  output logic                 fault_hit,
  output logic                 reset_catch
);
  logic [NUM_FAULT-1:0] line_ok;
  logic sec_block;
  assign sec_block = core_secure & ~sec_dbg_en;

  always_ff @(posedge clk) begin
    if (cold_rst)      catch_q <= '0;
    else if (catch_we) catch_q <= wr_bits;
  end

  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_line
    if (i == SEC_IDX) begin : g_sec
      assign line_ok[i] = sec_dbg_en;
    end else begin : g_norm
      assign line_ok[i] = ~sec_block;
    end
  end

  assign fault_hit   = dbg_en & |(fault_vec & catch_q[NUM_FAULT:1] & line_ok);
  assign reset_catch = dbg_en & catch_q[0];
endmodule

// File: rtl/dbg_ctrl_core.sv
module dbg_ctrl_core
  import dbg_halt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cold_rst,
  input  logic  ctrl_we,
  input  logic  en_we,
  input  logic  snap_we,
  input  ctrl_t wr_ctrl,
  input  logic  sec_dbg_en,
  input  logic  core_secure,
  input  logic  dbg_event,
  input  logic  fault_hit,
  input  logic  reset_catch,
  input  logic  step_done,
  input  logic  core_halt_ack,
  output ctrl_t ctrl_q,
  output logic  halt_o,
  output logic  step_o,
  output logic  mask_o,
  output logic  snap_o,
  output logic  halted_o
);
  logic sec_block, halt_nx, step_nx, set_halt;

  assign sec_block = core_secure & ~sec_dbg_en;
  assign halt_nx   = ctrl_q.en & ctrl_q.halt & ~sec_block;
  assign step_nx   = ctrl_q.en & ctrl_q.step & ~sec_block;
  assign set_halt  = ctrl_q.en &
                     (dbg_event | fault_hit | (step_done & step_nx & ~ctrl_q.halt));

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      ctrl_q <= '0;
    end else if (rst) begin
      ctrl_q.halt <= reset_catch;
      ctrl_q.step <= 1'b0;
      ctrl_q.mask <= 1'b0;
      ctrl_q.snap <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_q.halt <= wr_ctrl.halt;
        ctrl_q.step <= wr_ctrl.step;
        ctrl_q.mask <= wr_ctrl.mask;
      end
      if (en_we)    ctrl_q.en   <= wr_ctrl.en;
      if (snap_we)  ctrl_q.snap <= wr_ctrl.snap;
      if (set_halt) ctrl_q.halt <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cold_rst) begin
      halt_o   <= 1'b0;
      step_o   <= 1'b0;
      mask_o   <= 1'b0;
      snap_o   <= 1'b0;
      halted_o <= 1'b0;
    end else begin
      halt_o   <= halt_nx;
      step_o   <= step_nx;
      mask_o   <= ctrl_q.en & ctrl_q.mask;
      snap_o   <= ctrl_q.en & ctrl_q.snap;
      halted_o <= halt_nx & (halted_o | core_halt_ack);
    end
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA05F,
  parameter int NUM_FAULT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cold_rst,
  input  logic                 wr_en,
  input  logic                 wr_from_dbg,
  input  logic                 wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_sel,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 sec_dbg_en,
  input  logic                 core_secure,
  input  logic                 dbg_event,
  input  logic [NUM_FAULT-1:0] fault_vec,
  input  logic                 step_done,
  input  logic                 core_halt_ack,
  output logic                 halt_o,
  output logic                 step_o,
  output logic                 mask_o,
  output logic                 snap_o,
  output logic                 halted_o
);
  localparam int CATCH_W = NUM_FAULT + 1;

  logic  ctrl_we, en_we, snap_we, catch_we, fault_hit, reset_catch;
  ctrl_t wr_ctrl, ctrl_q;
  logic [CATCH_W-1:0] catch_q;
  logic [DATA_W-1:0]  ctrl_img, catch_img;
  logic rsvd_bits_unused;

  assign wr_ctrl = '{snap: wr_data[SNAP_POS], mask: wr_data[MASK_POS],
                     step: wr_data[STEP_POS], halt: wr_data[HALT_POS],
                     en:   wr_data[EN_POS]};
  assign rsvd_bits_unused = ^wr_data;

  dbg_wr_decode #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_from_dbg(wr_from_dbg),
    .wr_data(wr_data), .sec_dbg_en(sec_dbg_en),
    .ctrl_we(ctrl_we), .en_we(en_we), .snap_we(snap_we), .catch_we(catch_we)
  );

  dbg_catch_unit #(.NUM_FAULT(NUM_FAULT)) u_catch (
    .clk(clk), .cold_rst(cold_rst), .catch_we(catch_we),
    .wr_bits(wr_data[CATCH_W-1:0]), .dbg_en(ctrl_q.en),
    .sec_dbg_en(sec_dbg_en), .core_secure(core_secure),
    .fault_vec(fault_vec), .catch_q(catch_q),
    .fault_hit(fault_hit), .reset_catch(reset_catch)
  );

  dbg_ctrl_core u_core (
    .clk(clk), .rst(rst), .cold_rst(cold_rst),
    .ctrl_we(ctrl_we), .en_we(en_we), .snap_we(snap_we), .wr_ctrl(wr_ctrl),
    .sec_dbg_en(sec_dbg_en), .core_secure(core_secure),
    .dbg_event(dbg_event), .fault_hit(fault_hit), .reset_catch(reset_catch),
    .step_done(step_done), .core_halt_ack(core_halt_ack),
    .ctrl_q(ctrl_q), .halt_o(halt_o), .step_o(step_o), .mask_o(mask_o),
    .snap_o(snap_o), .halted_o(halted_o)
  );

  always_comb begin
    ctrl_img             = '0;
    ctrl_img[EN_POS]     = ctrl_q.en;
    ctrl_img[HALT_POS]   = ctrl_q.halt;
    ctrl_img[STEP_POS]   = ctrl_q.step;
    ctrl_img[MASK_POS]   = ctrl_q.mask;
    ctrl_img[SNAP_POS]   = ctrl_q.snap;
    ctrl_img[HALTED_POS] = halted_o;
    catch_img            = '0;
    catch_img[CATCH_W-1:0] = catch_q;
  end

  always_ff @(posedge clk) begin
    if (rst || cold_rst) rd_data <= '0;
    else                 rd_data <= rd_sel ? catch_img : ctrl_img;
  end
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk #(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
  input logic              clk,
  input logic              rst,
  input logic              cold_rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic              wr_from_dbg,
  input logic [DATA_W-1:0] wr_data,
  input logic              dbg_en_q,
  input logic              sec_dbg_en,
  input logic              core_secure,
  input logic              core_halt_ack,
  input logic              halt_o,
  input logic              step_o,
  input logic              mask_o,
  input logic              halted_o
);
  // R1
  bad_key_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (wr_en && !wr_sel && wr_data[DATA_W-1:DATA_W-KEY_W] != KEY) |=> $stable(dbg_en_q));

  // R3
  sw_enable_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (wr_en && !wr_from_dbg) |=> $stable(dbg_en_q));

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    mask_o |-> $past(dbg_en_q));

  // R5
  step_secure_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    step_o |-> $past(sec_dbg_en || !core_secure));

  // R9
  halted_req_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    halted_o |-> halt_o);

  // R9
  halted_ack_chk: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $rose(halted_o) |-> $past(core_halt_ack));
endmodule

bind dbg_halt_ctl dbg_halt_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .cold_rst(cold_rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_from_dbg(wr_from_dbg), .wr_data(wr_data), .dbg_en_q(ctrl_q.en),
  .sec_dbg_en(sec_dbg_en), .core_secure(core_secure),
  .core_halt_ack(core_halt_ack), .halt_o(halt_o), .step_o(step_o),
  .mask_o(mask_o), .halted_o(halted_o)
);

// File: tb/sim_dbg_halt_ctl.sv
module sim_dbg_halt_ctl;
  logic clk = 0, rst = 1, cold_rst = 1;
  logic wr_en = 0, wr_from_dbg = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic sec_dbg_en = 1, core_secure = 0, dbg_event = 0, step_done = 0, core_halt_ack = 0;
  logic [6:0] fault_vec = '0;
  logic halt_o, step_o, mask_o, snap_o, halted_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_halt_ctl u0 (.*);

  // {from_dbg, data, expected read, expected {snap,mask,step,halt}}
  localparam logic [68:0] VEC [8] = '{
    {1'b1, 32'hA05F_0001, 32'h0000_0001, 4'h0},
    {1'b1, 32'h1234_000F, 32'h0000_0001, 4'h0},
    {1'b0, 32'hA05F_0000, 32'h0000_0001, 4'h0},
    {1'b0, 32'hA05F_002E, 32'h0000_002F, 4'hF},
    {1'b1, 32'hA05F_0021, 32'h0000_0021, 4'h8},
    {1'b1, 32'hA05F_0000, 32'h0000_0000, 4'h0},
    {1'b1, 32'hA05F_000E, 32'h0000_000E, 4'h0},
    {1'b1, 32'hA05F_0001, 32'h0000_0001, 4'h0}
  };
  localparam string VTAG [8] = '{"R3", "R1", "R3", "R2", "R2", "R3", "R4", "R4"};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic dbg, logic sel, logic [31:0] d);
    wr_en = 1; wr_from_dbg = dbg; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(logic sel, logic [31:0] exp, string tag);
    rd_sel = sel;
    tick();
    check(tag, rd_data, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk); tick();
    rst = 0; cold_rst = 0;
    // R11 reset state
    check("R11 reset outputs", {27'b0, halted_o, snap_o, mask_o, step_o, halt_o}, 32'h0);
    rd(1'b0, 32'h0, "R2 reset read");

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][68], 1'b0, VEC[i][67:36]);
      tick();
      check({VTAG[i], " outputs"}, {28'b0, snap_o, mask_o, step_o, halt_o}, {28'b0, VEC[i][3:0]});
      check({VTAG[i], " read"}, rd_data, VEC[i][35:4]);
    end

    // R5 security gating
    wr(1'b1, 1'b0, 32'hA05F_0007); tick();
    check("R5 halt+step open", {30'b0, step_o, halt_o}, 32'h3);
    core_secure = 1; sec_dbg_en = 0; tick();
    check("R5 secure block", {30'b0, step_o, halt_o}, 32'h0);
    wr(1'b1, 1'b0, 32'hA05F_0027);
    rd(1'b0, 32'h0000_0007, "R5 snap ignored");
    core_secure = 0; sec_dbg_en = 1; tick();
    check("R11 halt back", {31'b0, halt_o}, 32'h1);

    // R9 halted status
    core_halt_ack = 1; tick(); core_halt_ack = 0;
    check("R9 halted set", {31'b0, halted_o}, 32'h1);
    rd(1'b0, 32'h0002_0007, "R9 halted read");
    wr(1'b1, 1'b0, 32'hA05F_0005); tick();
    check("R6 resume", {29'b0, halted_o, step_o, halt_o}, 32'h2);

    // R10 step completion
    step_done = 1; tick(); step_done = 0; tick();
    check("R10 step halts", {30'b0, step_o, halt_o}, 32'h3);

    // R6 event and warm reset
    wr(1'b1, 1'b0, 32'hA05F_0001); tick();
    check("R6 cleared", {31'b0, halt_o}, 32'h0);
    dbg_event = 1; tick(); dbg_event = 0; tick();
    check("R6 event halts", {31'b0, halt_o}, 32'h1);
    rst = 1; tick(); rst = 0;
    check("R6 warm reset out", {31'b0, halt_o}, 32'h0);
    rd(1'b0, 32'h0000_0001, "R6 warm reset read");

    // R7 vector catch
    wr(1'b0, 1'b1, 32'h0000_0004);
    fault_vec = 7'h01; tick(); fault_vec = 0; tick();
    check("R7 unarmed line", {31'b0, halt_o}, 32'h0);
    fault_vec = 7'h02; tick(); fault_vec = 0; tick();
    check("R7 armed line", {31'b0, halt_o}, 32'h1);
    wr(1'b1, 1'b0, 32'hA05F_0001);
    core_secure = 1; sec_dbg_en = 0;
    fault_vec = 7'h02; tick(); fault_vec = 0;
    core_secure = 0; sec_dbg_en = 1;
    rd(1'b0, 32'h0000_0001, "R7 secure state blocks");
    wr(1'b0, 1'b1, 32'h0000_0080);
    sec_dbg_en = 0; fault_vec = 7'h40; tick(); fault_vec = 0; sec_dbg_en = 1;
    rd(1'b0, 32'h0000_0001, "R7 secure fault blocked");
    fault_vec = 7'h40; tick(); fault_vec = 0;
    rd(1'b0, 32'h0000_0003, "R7 secure fault caught");
    rd(1'b1, 32'h0000_0080, "R7 catch read");

    // R8 reset catch
    wr(1'b1, 1'b0, 32'hA05F_0001);
    wr(1'b0, 1'b1, 32'h0000_0001);
    core_secure = 1; sec_dbg_en = 0;
    rst = 1; tick(); rst = 0;
    rd(1'b0, 32'h0000_0003, "R8 reset pends halt");
    check("R8 gated while secure", {31'b0, halt_o}, 32'h0);
    core_secure = 0; sec_dbg_en = 1; tick();
    check("R8 halt after release", {31'b0, halt_o}, 32'h1);

    // R3 R7 cold reset
    cold_rst = 1; tick(); cold_rst = 0;
    check("R11 cold outputs", {31'b0, halt_o}, 32'h0);
    rd(1'b0, 32'h0, "R3 cold clears enable");
    rd(1'b1, 32'h0, "R7 cold clears catch");

    summary();
  end
endmodule